// File: doc/BRIEF.md
# Justified Per-Period Pulse Width Modulator

This block produces one pulse on a single output line during every dot period. The pulse width is set by a binary code, and the pulse is placed at the start, at the end or in the middle of the period. The implementation is fully digital. A fast tick clock splits each dot period into `2**DW` slots, and a one-tick strobe on `period_stb` marks the start of each period.

Code and placement controls are sampled on the strobe tick. They pass through a two-stage pipeline, so each pulse appears in the period after its inputs were taken. The all-zero code and the all-ones code force a solid level for the whole period. A retrace input overrides the data and holds the line high. The output comes straight from a register on the tick clock. It has no glitches, and pulses that meet at a period boundary merge into one high level.

Top module: `justified_pwm`

## Requirements
- R1: While reset is held and after it is released, `pwm_out` is low, and both pipeline stages hold code 0, so the first period after reset is entirely low.
- R2: For a code w with 0 < w < 2**DW-1, the output is high for exactly w slots of the period.
- R3: With `single_edge`=1 and `lead_edge`=0 (left justified), slots 0 to w-1 are high and the rest are low.
- R4: With `single_edge`=1 and `lead_edge`=1 (right justified), slots 2**DW-w to 2**DW-1 are high and the rest are low.
- R5: With `single_edge`=0 (centred, `lead_edge` ignored), the high slots run from lo to lo+w-1, where lo = floor((2**DW-w)/2). For odd w the extra low slot therefore falls at the end.
- R6: Inputs sampled on a strobe tick take effect in the following period. On the k-th tick edge after a strobe edge (k = 0 at the strobe edge itself), the output shows slot k of the pulse captured at the previous strobe.
- R7: Code 0 gives a period that is low throughout. Code 2**DW-1 gives a period that is high throughout. Both hold for every combination of control bits.
- R8: While `retrace` is 1, the output is high from the following tick edge onwards. After `retrace` returns to 0, the output again follows the pipelined codes.
- R9: A right-justified pulse that reaches the last slot, followed by a pulse that starts at slot 0, gives a high level with no low tick across the boundary.
- R10: Code and control inputs may change every period. Changes between strobes have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, `2**DW` ticks per dot period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| period_stb | input | 1 | One-tick strobe that starts each dot period and samples the inputs |
| code | input | DW | Pulse width code, plain binary |
| single_edge | input | 1 | 1: one edge modulated; 0: centred pulse |
| lead_edge | input | 1 | With `single_edge`=1: 1 right justified, 0 left justified |
| retrace | input | 1 | Forces the output high while set |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench builds the block with DW=4, which gives 16 slots per period. At that size it can sweep every code under all four combinations of the two control bits and compare every slot of every period against arithmetic placement formulas. The small period also keeps short the runs that matter at the edges: the first period after reset, back-to-back right and left pulses across a boundary, retrace periods entered and left, and inputs disturbed in the middle of a period.

// File: rtl/jpwm_pkg.sv
package jpwm_pkg;

  typedef enum logic [1:0] {
    PL_LEFT   = 2'd0,
    PL_RIGHT  = 2'd1,
    PL_CENTER = 2'd2
  } place_t;

  function automatic place_t decode_place(input logic single_edge, input logic lead_edge);
    if (!single_edge) return PL_CENTER;
    else if (lead_edge) return PL_RIGHT;
    else return PL_LEFT;
  endfunction

endpackage

// File: rtl/jpwm_capture.sv
module jpwm_capture
  import jpwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] code_in,
  input  place_t        place_in,
  output logic [DW-1:0] act_code_n,
  output place_t        act_place_n
);

  logic [DW-1:0] hold_code_q, hold_code_d;
  logic [DW-1:0] act_code_q, act_code_d;
  place_t        hold_place_q, hold_place_d;
  place_t        act_place_q, act_place_d;

  always_comb begin
    hold_code_d  = hold_code_q;
    hold_place_d = hold_place_q;
    act_code_d   = act_code_q;
    act_place_d  = act_place_q;
    if (load) begin
      hold_code_d  = code_in;
      hold_place_d = place_in;
      act_code_d   = hold_code_q;
      act_place_d  = hold_place_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_code_q  <= '0;
      hold_place_q <= PL_LEFT;
      act_code_q   <= '0;
      act_place_q  <= PL_LEFT;
    end else if (load) begin
      hold_code_q  <= hold_code_d;
      hold_place_q <= hold_place_d;
      act_code_q   <= act_code_d;
      act_place_q  <= act_place_d;
    end
  end

  assign act_code_n  = act_code_d;
  assign act_place_n = act_place_d;

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_code_q) && $stable(act_place_q))); // R10
  AST_ACT_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (act_code_q == $past(hold_code_q))); // R6

endmodule

// File: rtl/jpwm_slot_counter.sv
module jpwm_slot_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [DW-1:0] slot_n
);

  logic [DW-1:0] slot_q, slot_d;

  always_comb begin
    if (restart) slot_d = '0;
    else         slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_n = slot_d;

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (slot_q == $past(slot_q) + 1'b1)); // R6

endmodule

// File: rtl/jpwm_shaper.sv
module jpwm_shaper
  import jpwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] act_code,
  input  place_t        act_place,
  input  logic [DW-1:0] slot,
  input  logic          retrace,
  output logic          pwm_q
);

  localparam int SLOTS = 1 << DW;
  localparam logic [DW-1:0] CODE_FULL = '1;

  logic [DW-1:0] right_start;
  logic [DW:0]   span;
  logic [DW-1:0] center_lo;
  logic [DW:0]   center_end;
  logic          pulse_d, pwm_d;

  always_comb begin
    right_start = '0 - act_code;
    span        = (DW+1)'(SLOTS) - {1'b0, act_code};
    center_lo   = span[DW:1];
    center_end  = {1'b0, center_lo} + {1'b0, act_code};
    if (act_code == '0) begin
      pulse_d = 1'b0;
    end else if (act_code == CODE_FULL) begin
      pulse_d = 1'b1;
    end else begin
      unique case (act_place)
        PL_LEFT:  pulse_d = (slot < act_code);
        PL_RIGHT: pulse_d = (slot >= right_start);
        default:  pulse_d = (slot >= center_lo) && ({1'b0, slot} < center_end);
      endcase
    end
    pwm_d = retrace | pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == '0 && !retrace) |=> !pwm_q); // R7
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (act_code == CODE_FULL) |=> pwm_q); // R7
  AST_RETRACE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    retrace |=> pwm_q); // R8
  AST_LEFT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (act_place == PL_LEFT && act_code != '0 && slot == '0) |=> pwm_q); // R3
  AST_RIGHT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (act_place == PL_RIGHT && act_code != '0 && slot == '1) |=> pwm_q); // R4

endmodule

// File: rtl/justified_pwm.sv
module justified_pwm
  import jpwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          period_stb,
  input  logic [DW-1:0] code,
  input  logic          single_edge,
  input  logic          lead_edge,
  input  logic          retrace,
  output logic          pwm_out
);

  logic          rst_meta_q, rst_sync_q;
  logic [DW-1:0] act_code_n;
  place_t        act_place_n;
  logic [DW-1:0] slot_n;
  place_t        place_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign place_in = decode_place(single_edge, lead_edge);

  jpwm_capture #(.DW(DW)) u_capture (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .load        (period_stb),
    .code_in     (code),
    .place_in    (place_in),
    .act_code_n  (act_code_n),
    .act_place_n (act_place_n)
  );

  jpwm_slot_counter #(.DW(DW)) u_counter (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .restart (period_stb),
    .slot_n  (slot_n)
  );

  jpwm_shaper #(.DW(DW)) u_shaper (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .act_code  (act_code_n),
    .act_place (act_place_n),
    .slot      (slot_n),
    .retrace   (retrace),
    .pwm_q     (pwm_out)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_sync_q |-> !pwm_out); // R1

endmodule

// File: tb/justified_pwm_bench.sv
module justified_pwm_bench;

  localparam int DW    = 4;
  localparam int SLOTS = 1 << DW;
  localparam int MAXC  = SLOTS - 1;

  logic          clk;
  logic          rst_n;
  logic          period_stb;
  logic [DW-1:0] code;
  logic          single_edge;
  logic          lead_edge;
  logic          retrace;
  logic          pwm_out;

  int n_cmp;
  int n_bad;
  bit done;

  int    it_code [120];
  bit    it_sgl  [120];
  bit    it_ld   [120];
  bit    it_rt   [120];
  string it_tag  [120];
  int    n_items;

  justified_pwm #(.DW(DW)) u_justified_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_stb  (period_stb),
    .code        (code),
    .single_edge (single_edge),
    .lead_edge   (lead_edge),
    .retrace     (retrace),
    .pwm_out     (pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit exp_hi(int w, bit sgl, bit ld, int s);
    int lo;
    if (w == 0) return 1'b0;
    if (w == MAXC) return 1'b1;
    if (sgl && !ld) return (s < w);
    if (sgl && ld) return (s >= SLOTS - w);
    lo = (SLOTS - w) / 2;
    return (s >= lo) && (s < lo + w);
  endfunction

  task automatic push(int c, bit sgl, bit ld, bit rt, string tag);
    it_code[n_items] = c;
    it_sgl[n_items]  = sgl;
    it_ld[n_items]   = ld;
    it_rt[n_items]   = rt;
    it_tag[n_items]  = tag;
    n_items++;
  endtask

  task automatic check(int act, int exp, string tag, int p, int s);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s period %0d slot %0d: got %0d expected %0d", tag, p, s, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0; n_items = 0;
    rst_n = 1'b0; period_stb = 1'b0; code = '0;
    single_edge = 1'b0; lead_edge = 1'b0; retrace = 1'b0;

    // R6: first captured pulse shows one period later
    push(9, 1, 0, 0, "R6");
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < SLOTS; c++) begin
        string tg;
        if (c == 0 || c == MAXC) tg = "R7";
        else if (m < 2)          tg = "R5";
        else if (m == 2)         tg = "R3";
        else                     tg = "R4";
        push(c, m >= 2, m[0], 0, tg);
      end
    end
    push(6, 0, 0, 0, "R10");
    push(14, 1, 1, 0, "R9");
    push(14, 1, 0, 0, "R9");
    push(MAXC, 1, 1, 0, "R9");
    push(3, 1, 0, 0, "R9");
    push(5, 1, 0, 1, "R8");
    push(3, 1, 1, 0, "R8");
    push(0, 0, 0, 1, "R8");
    push(0, 0, 0, 0, "R8");
    push(0, 0, 0, 0, "R1");

    repeat (3) @(negedge clk);
    // R1: output low while reset held
    check(pwm_out, 0, "R1", -1, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_out, 0, "R1", -1, 0);

    for (int p = 0; p < n_items; p++) begin
      int    pc, cnt;
      bit    ps, pl;
      string ptag;
      if (p == 0) begin
        pc = 0; ps = 0; pl = 0; ptag = "R1";
      end else begin
        pc = it_code[p-1]; ps = it_sgl[p-1]; pl = it_ld[p-1]; ptag = it_tag[p-1];
      end
      period_stb  = 1'b1;
      code        = DW'(it_code[p]);
      single_edge = it_sgl[p];
      lead_edge   = it_ld[p];
      retrace     = it_rt[p];
      cnt = 0;
      for (int s = 0; s < SLOTS; s++) begin
        int e;
        @(posedge clk);
        @(negedge clk);
        if (s == 0) period_stb = 1'b0;
        if (s == 5) begin
          // R10: mid-period input disturbance must not matter
          code        = ~code;
          single_edge = ~single_edge;
          lead_edge   = ~lead_edge;
        end
        e = it_rt[p] ? 1 : int'(exp_hi(pc, ps, pl, s));
        if (pwm_out) cnt++;
        check(pwm_out, e, it_rt[p] ? "R8" : ptag, p, s);
      end
      if (!it_rt[p] && pc > 0 && pc < MAXC)
        check(cnt, pc, "R2", p, SLOTS);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

endmodule